// File: doc/BRIEF.md
# PLL Control and Lock Monitor

This block is the control and status front end for one phase-locked loop inside a clock generation unit. Software writes a 32-bit control word over a simple word-addressed register bus. The word holds a power-down bit, a bypass bit, three divider fields and a band field. The block keeps this word and decodes the divider fields, which use non-linear encodings, into their effective divide values. It drives a registered frequency ratio (numerator and denominator), so the synthesized rate is reference × numerator / denominator.

The analog loop is modelled as a lock-delay counter. Every control write drops the lock and error flags and restarts the counter. When the counter expires, the block raises lock unless the loop is powered down. At the same point it raises error if the VCO multiplication (feedback over input divider) falls outside a legal window set by parameters. Software reads the two flags back from a status word.

The register window has four words. Word 0 is control and word 1 is status. Words 2 and 3 (frequency measurement and monitor) are not implemented: they read zero and ignore writes.

Top module: `pll_ctrl_mon`

## Requirements
- R1: In the cycles after a synchronous reset, the control word reads 0x00000001 (power-down set), the status word reads 0, and lock and error are low.
- R2: A write to word 0 stores these fields: bit 0 power-down, bit 1 bypass, bits 3:2 output-divider field, bits 8:4 input-divider field, bits 15:9 feedback field, bits 21:20 band. All other bits read back zero (implemented mask 0x0030FFFF). Read data for a request appears on the edge that accepts the request and holds until the next read.
- R3: One edge after the control word changes, the effective dividers show the new value: input = field + 1, feedback = 2 × (field + 1), output = 2 raised to the field.
- R4: The ratio outputs give 0/1 when power-down is set, and 1/1 when bypass is set with power-down clear; power-down takes priority. Otherwise they give feedback / (input × output). They update on the same cycle as the dividers.
- R5: A control write clears lock and error on its own edge and loads a LOCK_CYCLES counter. Lock rises exactly LOCK_CYCLES edges after the last control write. A write made while the counter runs restarts the count.
- R6: When the counter expires with power-down clear, error is set if feedback < VCO_MIN_MUL × input or feedback > VCO_MAX_MUL × input, and is clear otherwise. The next control write clears it.
- R7: Word 1 (byte 0x4) reads lock in bit 0 and error in bit 1; all other bits are zero.
- R8: Words 2 and 3 (bytes 0x8, 0xC) read zero. Writes to words 1, 2 and 3 change neither the control word nor the lock timer.
- R9: With power-down set, lock and error stay low after the counter expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one per cycle |
| bus_rd | input | 1 | Read strobe, one per cycle |
| bus_word | input | 2 | Word index in the window (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pll_locked | output | 1 | Lock flag |
| pll_error | output | 1 | VCO range error flag |
| eff_in_div | output | IDIV_W+1 | Effective input divider |
| eff_fb_div | output | FBDIV_W+2 | Effective feedback divider |
| eff_out_div | output | 2**ODIV_W | Effective output divider |
| ratio_num | output | FBDIV_W+2 | Rate ratio numerator |
| ratio_den | output | IDIV_W+1+2**ODIV_W | Rate ratio denominator |

## Verification
The bench builds the block with LOCK_CYCLES at 8 in place of the default microsecond-scale count. Many full lock sequences, and restarts in the middle of a count, then fit in a short run. VCO_MIN_MUL and VCO_MAX_MUL keep their defaults of 6 and 60. Small field values therefore reach both edges of the legal window exactly: a feedback of 6 over an input of 1 is legal and 4 is not, and 120 over 2 is legal while 122 over 2 is not.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  // word index inside the four-word register window
  typedef enum logic [1:0] {
    RW_CTRL = 2'd0,
    RW_STAT = 2'd1,
    RW_MEAS = 2'd2,
    RW_MON  = 2'd3
  } reg_word_e;

  function automatic logic [31:0] field_mask(input int lsb, input int width);
    return ((32'h1 << width) - 32'h1) << lsb;
  endfunction
endpackage

// File: rtl/pllc_regs.sv
module pllc_regs import pllc_pkg::*; #(
  parameter logic [31:0] CTRL_MASK = 32'h0030FFFF,
  parameter logic [31:0] RST_CTRL  = 32'h00000001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_word,
  input  logic [31:0] bus_wdata,
  input  logic        lock_in,
  input  logic        err_in,
  output logic [31:0] ctrl_q,
  output logic        ctrl_wr,
  output logic [31:0] rdata
);
  reg_word_e   word;
  logic [31:0] rd_mux;

  always_comb begin
    word    = reg_word_e'(bus_word);
    ctrl_wr = bus_wr && (word == RW_CTRL);
    unique case (word)
      RW_CTRL: rd_mux = ctrl_q;
      RW_STAT: rd_mux = {30'b0, err_in, lock_in};
      default: rd_mux = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= RST_CTRL & CTRL_MASK;
      rdata  <= 32'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_MASK;
      if (bus_rd)  rdata  <= rd_mux;
    end
  end
endmodule

// File: rtl/pllc_decode.sv
module pllc_decode #(
  parameter int ODIV_W      = 2,
  parameter int IDIV_W      = 5,
  parameter int FBDIV_W     = 7,
  parameter int VCO_MIN_MUL = 6,
  parameter int VCO_MAX_MUL = 60,
  localparam int LO_W  = 2 + ODIV_W + IDIV_W + FBDIV_W,
  localparam int OUT_W = 2 ** ODIV_W,
  localparam int NUM_W = FBDIV_W + 2,
  localparam int DEN_W = IDIV_W + 1 + OUT_W
) (
  input  logic [LO_W-1:0]     ctrl_lo,
  output logic [IDIV_W:0]     in_div,
  output logic [NUM_W-1:0]    fb_div,
  output logic [OUT_W-1:0]    out_div,
  output logic [NUM_W-1:0]    num,
  output logic [DEN_W-1:0]    den,
  output logic                vco_bad
);
  localparam int ODIV_LSB  = 2;
  localparam int IDIV_LSB  = ODIV_LSB + ODIV_W;
  localparam int FBDIV_LSB = IDIV_LSB + IDIV_W;

  logic               pd, byp;
  logic [ODIV_W-1:0]  of;
  logic [IDIV_W-1:0]  inf;
  logic [FBDIV_W-1:0] fbf;
  logic [DEN_W-1:0]   prod;
  logic [31:0]        fb32, lo32, hi32;

  assign pd  = ctrl_lo[0];
  assign byp = ctrl_lo[1];
  assign of  = ctrl_lo[IDIV_LSB-1:ODIV_LSB];
  assign inf = ctrl_lo[FBDIV_LSB-1:IDIV_LSB];
  assign fbf = ctrl_lo[LO_W-1:FBDIV_LSB];

  assign in_div = {1'b0, inf} + {{IDIV_W{1'b0}}, 1'b1};
  assign fb_div = {({1'b0, fbf} + {{FBDIV_W{1'b0}}, 1'b1}), 1'b0};

  // output divider is a one-hot power of two
  for (genvar g = 0; g < OUT_W; g++) begin : g_odiv
    assign out_div[g] = (of == ODIV_W'(g));
  end

  assign prod = DEN_W'(in_div) * DEN_W'(out_div);

  always_comb begin
    if (pd) begin
      num = '0;
      den = DEN_W'(1);
    end else if (byp) begin
      num = NUM_W'(1);
      den = DEN_W'(1);
    end else begin
      num = fb_div;
      den = prod;
    end
    fb32    = 32'(fb_div);
    lo32    = 32'(VCO_MIN_MUL) * 32'(in_div);
    hi32    = 32'(VCO_MAX_MUL) * 32'(in_div);
    vco_bad = (fb32 < lo32) || (fb32 > hi32);
  end
endmodule

// File: rtl/pllc_lock_timer.sv
module pllc_lock_timer #(
  parameter int LOCK_CYCLES = 3334,
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic pd,
  input  logic vco_bad,
  output logic locked,
  output logic err
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      locked <= 1'b0;
      err    <= 1'b0;
    end else if (restart) begin
      cnt    <= CNT_W'(LOCK_CYCLES);
      locked <= 1'b0;
      err    <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) begin
        locked <= !pd;
        err    <= !pd && vco_bad;
      end
    end
  end
endmodule

// File: rtl/pll_ctrl_mon.sv
module pll_ctrl_mon import pllc_pkg::*; #(
  parameter int ODIV_W      = 2,
  parameter int IDIV_W      = 5,
  parameter int FBDIV_W     = 7,
  parameter int BAND_LSB    = 20,
  parameter int BAND_W      = 2,
  parameter int LOCK_CYCLES = 3334,
  parameter int VCO_MIN_MUL = 6,
  parameter int VCO_MAX_MUL = 60
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic [1:0]                        bus_word,
  input  logic [31:0]                       bus_wdata,
  output logic [31:0]                       bus_rdata,
  output logic                              pll_locked,
  output logic                              pll_error,
  output logic [IDIV_W:0]                   eff_in_div,
  output logic [FBDIV_W+1:0]                eff_fb_div,
  output logic [2**ODIV_W-1:0]              eff_out_div,
  output logic [FBDIV_W+1:0]                ratio_num,
  output logic [IDIV_W+2**ODIV_W:0]         ratio_den
);
  localparam int LO_W  = 2 + ODIV_W + IDIV_W + FBDIV_W;
  localparam int OUT_W = 2 ** ODIV_W;
  localparam int NUM_W = FBDIV_W + 2;
  localparam int DEN_W = IDIV_W + 1 + OUT_W;
  localparam logic [31:0] CTRL_MASK = field_mask(0, LO_W) | field_mask(BAND_LSB, BAND_W);

  logic [31:0]       ctrl_q;
  logic              ctrl_wr;
  logic              lock_s, err_s;
  logic [IDIV_W:0]   in_d;
  logic [NUM_W-1:0]  fb_d, num_d;
  logic [OUT_W-1:0]  out_d;
  logic [DEN_W-1:0]  den_d;
  logic              vco_bad;

  pllc_regs #(.CTRL_MASK(CTRL_MASK), .RST_CTRL(32'h1)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_word(bus_word), .bus_wdata(bus_wdata),
    .lock_in(lock_s), .err_in(err_s),
    .ctrl_q(ctrl_q), .ctrl_wr(ctrl_wr), .rdata(bus_rdata)
  );

  pllc_decode #(
    .ODIV_W(ODIV_W), .IDIV_W(IDIV_W), .FBDIV_W(FBDIV_W),
    .VCO_MIN_MUL(VCO_MIN_MUL), .VCO_MAX_MUL(VCO_MAX_MUL)
  ) u_dec (
    .ctrl_lo(ctrl_q[LO_W-1:0]), .in_div(in_d), .fb_div(fb_d), .out_div(out_d),
    .num(num_d), .den(den_d), .vco_bad(vco_bad)
  );

  pllc_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .restart(ctrl_wr), .pd(ctrl_q[0]),
    .vco_bad(vco_bad), .locked(lock_s), .err(err_s)
  );

  // register the decoded view so the multiplier stays off the output path
  always_ff @(posedge clk) begin
    eff_in_div  <= in_d;
    eff_fb_div  <= fb_d;
    eff_out_div <= out_d;
    ratio_num   <= num_d;
    ratio_den   <= den_d;
  end

  assign pll_locked = lock_s;
  assign pll_error  = err_s;
endmodule

// File: rtl/pll_ctrl_mon_chk.sv
module pll_ctrl_mon_chk #(
  parameter int LOCK_CYCLES = 3334,
  parameter int NUM_W = 9,
  parameter int DEN_W = 10,
  localparam int SW = $clog2(LOCK_CYCLES + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_word,
  input logic [31:0]       bus_rdata,
  input logic              pll_locked,
  input logic              pll_error,
  input logic [NUM_W-1:0]  ratio_num,
  input logic [DEN_W-1:0]  ratio_den,
  input logic              ctrl_pd
);
  logic          cwr;
  logic [SW-1:0] since;

  assign cwr = bus_wr && (bus_word == 2'd0);

  // cycles since the last control write, saturating
  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (cwr) since <= SW'(1);
    else if (since != '0 && since < SW'(LOCK_CYCLES + 1)) since <= since + SW'(1);
  end

  p_wr_clears_r5: assert property (@(posedge clk) disable iff (rst)
    cwr |=> (!pll_locked && !pll_error));

  p_lock_delay_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_locked) |-> (since == SW'(LOCK_CYCLES + 1)));

  p_pd_no_lock_r9: assert property (@(posedge clk) disable iff (rst)
    pll_locked |-> !ctrl_pd);

  p_status_read_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_word == 2'd1) |=> (bus_rdata == {30'b0, $past(pll_error), $past(pll_locked)}));

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_word[1]) |=> (bus_rdata == 32'b0));

  p_pd_ratio_r4: assert property (@(posedge clk) disable iff (rst)
    (ratio_num == '0) |-> (ratio_den == DEN_W'(1)));
endmodule

bind pll_ctrl_mon pll_ctrl_mon_chk #(
  .LOCK_CYCLES(LOCK_CYCLES), .NUM_W(FBDIV_W + 2), .DEN_W(IDIV_W + 1 + 2**ODIV_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word),
  .bus_rdata(bus_rdata), .pll_locked(pll_locked), .pll_error(pll_error),
  .ratio_num(ratio_num), .ratio_den(ratio_den), .ctrl_pd(ctrl_q[0])
);

// File: tb/sim_pll_ctrl_mon.sv
module sim_pll_ctrl_mon;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_word = 2'd0;
  logic [31:0] bus_wdata = 32'b0;
  logic [31:0] bus_rdata;
  logic pll_locked, pll_error;
  logic [5:0] eff_in_div;
  logic [8:0] eff_fb_div;
  logic [3:0] eff_out_div;
  logic [8:0] ratio_num;
  logic [9:0] ratio_den;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_ctrl_mon #(.LOCK_CYCLES(LOCK)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_locked(pll_locked),
    .pll_error(pll_error), .eff_in_div(eff_in_div), .eff_fb_div(eff_fb_div),
    .eff_out_div(eff_out_div), .ratio_num(ratio_num), .ratio_den(ratio_den)
  );

  int nchk = 0, nfail = 0;
  bit chk_on = 0;
  bit done = 0;
  string cur_tag = "R2";

  // reference model state
  logic [31:0] m_ctrl = 32'h0, m_rdata = 32'h0;
  bit m_lock = 0, m_err = 0;
  int m_cnt = 0;
  int e_in = 0, e_fb = 0, e_out = 0, e_num = 0, e_den = 0;

  function automatic int f_in(logic [31:0] c);  return ((c >> 4) & 31) + 1;     endfunction
  function automatic int f_fb(logic [31:0] c);  return 2 * (((c >> 9) & 127) + 1); endfunction
  function automatic int f_out(logic [31:0] c); return 1 << ((c >> 2) & 3);      endfunction
  function automatic bit f_bad(logic [31:0] c);
    return (f_fb(c) < 6 * f_in(c)) || (f_fb(c) > 60 * f_in(c));
  endfunction

  always @(posedge clk) begin
    logic [31:0] oc;
    bit ol, oe;
    oc = m_ctrl; ol = m_lock; oe = m_err;
    e_in  = f_in(oc);
    e_fb  = f_fb(oc);
    e_out = f_out(oc);
    if (oc[0])      begin e_num = 0; e_den = 1; end
    else if (oc[1]) begin e_num = 1; e_den = 1; end
    else            begin e_num = e_fb; e_den = e_in * e_out; end
    if (rst) begin
      m_ctrl = 32'h1; m_lock = 0; m_err = 0; m_cnt = 0; m_rdata = 0;
    end else begin
      if (bus_rd) begin
        if (bus_word == 2'd0)      m_rdata = oc;
        else if (bus_word == 2'd1) m_rdata = {30'b0, oe, ol};
        else                       m_rdata = 32'b0;
      end
      if (bus_wr && bus_word == 2'd0) begin
        m_ctrl = bus_wdata & 32'h0030FFFF;
        m_lock = 0; m_err = 0; m_cnt = LOCK;
      end else if (m_cnt > 0) begin
        if (m_cnt == 1) begin
          m_lock = !oc[0];
          m_err  = !oc[0] && f_bad(oc);
        end
        m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk(cur_tag, "rdata", bus_rdata, m_rdata);
      chk(m_ctrl[0] ? "R9" : "R5", "lock", pll_locked, m_lock);
      chk(m_ctrl[0] ? "R9" : "R6", "error", pll_error, m_err);
      chk("R3", "in_div", eff_in_div, e_in);
      chk("R3", "fb_div", eff_fb_div, e_fb);
      chk("R3", "out_div", eff_out_div, e_out);
      chk("R4", "ratio_num", ratio_num, e_num);
      chk("R4", "ratio_den", ratio_den, e_den);
    end
  end

  task automatic drive(bit w, bit r, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_word = a; bus_wdata = d;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 2'd0, 32'h0);
  endtask
  task automatic wr(logic [1:0] a, logic [31:0] d); drive(1, 0, a, d); endtask
  task automatic rd(logic [1:0] a); drive(0, 1, a, 32'h0); endtask

  function automatic logic [31:0] cw(int fb, int in, int od, bit byp, bit pd);
    return (32'(fb) << 9) | (32'(in) << 4) | (32'(od) << 2) | (32'(byp) << 1) | 32'(pd);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_on = 1;
    // R1: reset state readback
    cur_tag = "R1";
    rd(2'd0); rd(2'd1); idle(1);
    // R8: unused words read zero
    cur_tag = "R8";
    rd(2'd2); rd(2'd3); idle(1);
    // R2: all-ones write is masked; power-down set, so R9 applies
    cur_tag = "R2";
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0); idle(LOCK + 2);
    cur_tag = "R9";
    rd(2'd1); idle(1);
    // R5: normal config, then restart mid-count
    cur_tag = "R5";
    wr(2'd0, cw(47, 1, 1, 0, 0) | 32'h0010_0000); idle(3);
    wr(2'd0, cw(47, 1, 1, 0, 0)); idle(LOCK + 2); rd(2'd1); idle(1);
    // R8: writes to status and unused words do nothing
    cur_tag = "R8";
    wr(2'd1, 32'h0); wr(2'd2, 32'hFFFF_FFFF); wr(2'd3, 32'h1); idle(2);
    rd(2'd0); rd(2'd1); idle(1);
    // R4: bypass
    cur_tag = "R4";
    wr(2'd0, cw(20, 0, 1, 1, 0)); idle(LOCK + 1); rd(2'd0); idle(1);
    // R6: VCO window edges
    cur_tag = "R6";
    wr(2'd0, cw(2, 0, 0, 0, 0));  idle(LOCK + 1); rd(2'd1); idle(1);
    wr(2'd0, cw(1, 0, 0, 0, 0));  idle(LOCK + 1); rd(2'd1); idle(1);
    wr(2'd0, cw(59, 1, 3, 0, 0)); idle(LOCK + 1); rd(2'd1); idle(1);
    wr(2'd0, cw(60, 1, 3, 0, 0)); idle(LOCK + 1); rd(2'd1); idle(1);
    cur_tag = "R7";
    rd(2'd1); wr(2'd0, cw(23, 0, 1, 0, 0)); rd(2'd1); idle(LOCK + 1); rd(2'd1); idle(1);
    // mixed traffic
    cur_tag = "R2";
    for (int i = 0; i < 120; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ((i % 3) != 0) d[0] = 1'b0;
      drive(($urandom % 2) == 1, ($urandom % 2) == 1, 2'($urandom % 4), d);
      if ((i % 5) == 0) idle(int'($urandom % (LOCK + 3)));
    end
    idle(LOCK + 2);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule